// File: doc/BRIEF.md
# Display and Machine-Control I/O Registers

This block sits beside a processor's load/store port and decodes three fixed addresses inside a small I/O window. A status word tells software whether the display path can take another character. A data word hands one character to a display sink over a valid/ready stream. A control word carries the run latch that enables the processor clock. Software polls the status word until its top bit is 1, stores a character to the data word, and stops the machine by storing a control value whose top bit is 0.

The CPU side is a single-cycle bus with address, write strobe, write data and a combinational read return. Accesses outside the three addresses leave every register alone, return zero and deassert the select output, so that the memory path answers them instead. A store to the data word while a character is still waiting is dropped and raises a sticky overrun flag.

Top module: `disp_io_regs`

## Requirements
- R1: After reset the run latch and `run_en` are 1, `char_valid` is 0, `ovr_flag` is 0, the status word reads 16'h8000 and the control word reads 16'h8000.
- R2: A read of address 16'hFE04 returns the ready bit in bit 15 (1 = a character may be stored, 0 = busy) and 0 in bits 14..0; stores to this address change nothing.
- R3: A store to address 16'hFE06 while the ready bit is 1 presents bits 7..0 of the store data on `char_data` with `char_valid` high from the next cycle, and the ready bit reads 0 from that cycle.
- R4: `char_valid` stays high and `char_data` stays unchanged until a cycle in which `char_ready` is high; from the cycle after that acceptance `char_valid` is 0 and the ready bit reads 1.
- R5: A store to 16'hFE06 while the ready bit is 0 (including the very cycle in which the sink accepts) leaves the pending character and the data word unchanged and sets `ovr_flag`, which then stays 1 until reset.
- R6: A read of address 16'hFE06 returns the last character taken in bits 7..0 and 0 in bits 15..8.
- R7: A store to address 16'hFFFE writes all 16 bits of the control word, which reads back as written; `run_en` equals control bit 15 from the cycle after the store, so storing a value with bit 15 cleared stops the machine.
- R8: Any other address leaves every register unchanged, reads as 0 and holds `io_sel` at 0; `io_sel` is 1 for the three decoded addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 16 | CPU access address |
| bus_we | input | 1 | Store strobe for the current cycle |
| bus_wdata | input | 16 | Store data |
| bus_rdata | output | 16 | Read return for the current address |
| io_sel | output | 1 | High when the address is one of the three registers |
| char_valid | output | 1 | A character is waiting for the sink |
| char_data | output | 8 | Character offered to the sink |
| char_ready | input | 1 | Sink takes the character this cycle |
| ovr_flag | output | 1 | Sticky flag: a store hit the data word while busy |
| run_en | output | 1 | Processor clock enable, equal to the run latch |

## Verification
The sink's acceptance and a new store to the data word can land in the same cycle. The bench raises `char_ready` and drives a data store on one clock edge. It then expects the old character to be gone, `char_valid` low, the ready bit back at 1, the data word still holding the old character, and `ovr_flag` set, because software saw the busy state in that cycle.

// File: rtl/disp_io_regs.sv
module disp_io_regs #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter int CHAR_W = 8,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 16'hFE04,
  parameter logic [ADDR_W-1:0] CHAR_ADDR = 16'hFE06,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 16'hFFFE
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              io_sel,
  output logic              char_valid,
  output logic [CHAR_W-1:0] char_data,
  input  logic              char_ready,
  output logic              ovr_flag,
  output logic              run_en
);
  localparam int TOP = DATA_W - 1;
  localparam int PAD = DATA_W - CHAR_W;
  localparam logic [DATA_W-1:0] CTRL_RST = {1'b1, {(DATA_W-1){1'b0}}};

  logic              pend_q;
  logic [CHAR_W-1:0] chr_q;
  logic [DATA_W-1:0] ctl_q;
  logic              ovr_q;

  wire hit_stat = (bus_addr == STAT_ADDR);
  wire hit_char = (bus_addr == CHAR_ADDR);
  wire hit_ctrl = (bus_addr == CTRL_ADDR);
  wire wr_char  = bus_we && hit_char;
  wire wr_ctrl  = bus_we && hit_ctrl;
  wire take     = wr_char && !pend_q;

  assign io_sel     = hit_stat || hit_char || hit_ctrl;
  assign char_valid = pend_q;
  assign char_data  = chr_q;
  assign ovr_flag   = ovr_q;
  assign run_en     = ctl_q[TOP];

  always_comb begin
    bus_rdata = '0;
    if (hit_stat)      bus_rdata = {!pend_q, {(DATA_W-1){1'b0}}};
    else if (hit_char) bus_rdata = {{PAD{1'b0}}, chr_q};
    else if (hit_ctrl) bus_rdata = ctl_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      chr_q  <= '0;
      ovr_q  <= 1'b0;
    end else begin
      if (take) begin
        pend_q <= 1'b1;
        chr_q  <= bus_wdata[CHAR_W-1:0];
      end else if (pend_q && char_ready) begin
        pend_q <= 1'b0;
      end
      if (wr_char && pend_q) ovr_q <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctl_q <= CTRL_RST;
    else if (wr_ctrl) ctl_q <= bus_wdata;
  end

  assert_take_char_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && hit_char && !char_valid) |=>
      (char_valid && char_data == $past(bus_wdata[CHAR_W-1:0])));

  assert_hold_char_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (char_valid && !char_ready) |=> (char_valid && $stable(char_data)));

  assert_ovr_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_flag |=> ovr_flag);

  assert_busy_store_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && hit_char && char_valid) |=> (ovr_flag && $stable(char_data)));

  assert_stop_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(run_en) |-> $past(bus_we && hit_ctrl && !bus_wdata[TOP]));

  assert_outside_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && !io_sel) |=> ($stable(run_en) && $stable(char_data)));

  assert_outside_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !io_sel |-> (bus_rdata == '0));
endmodule

// File: tb/sim_disp_io_regs.sv
module sim_disp_io_regs;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        io_sel;
  logic        char_valid;
  logic [7:0]  char_data;
  logic        char_ready = 1'b0;
  logic        ovr_flag;
  logic        run_en;

  int n_chk = 0;
  int n_bad = 0;
  logic [15:0] rd;

  always #10ns clk = ~clk;

  disp_io_regs u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .io_sel(io_sel),
    .char_valid(char_valid), .char_data(char_data), .char_ready(char_ready),
    .ovr_flag(ovr_flag), .run_en(run_en)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; bus_we = 1'b0; char_ready = 1'b0; bus_addr = '0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr(input logic [15:0] a, input logic [15:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0; bus_addr = '0;
  endtask

  task automatic rdw(input logic [15:0] a, output logic [15:0] d);
    bus_addr = a;
    #1ns;
    d = bus_rdata;
    bus_addr = '0;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 run_en", {15'd0, run_en}, 16'd1);
    chk("R1 char_valid", {15'd0, char_valid}, 16'd0);
    chk("R1 ovr_flag", {15'd0, ovr_flag}, 16'd0);
    rdw(16'hFE04, rd); chk("R1 status", rd, 16'h8000);
    rdw(16'hFFFE, rd); chk("R1 control", rd, 16'h8000);
  endtask

  task automatic t_send();
    do_reset();
    wr(16'hFE06, 16'hAB41);
    chk("R3 valid", {15'd0, char_valid}, 16'd1);
    chk("R3 data", {8'd0, char_data}, 16'h0041);
    rdw(16'hFE04, rd); chk("R2 status busy", rd, 16'h0000);
    rdw(16'hFE06, rd); chk("R6 data read", rd, 16'h0041);
    repeat (3) @(negedge clk);
    chk("R4 held valid", {15'd0, char_valid}, 16'd1);
    chk("R4 held data", {8'd0, char_data}, 16'h0041);
    char_ready = 1'b1;
    @(negedge clk);
    char_ready = 1'b0;
    chk("R4 released", {15'd0, char_valid}, 16'd0);
    rdw(16'hFE04, rd); chk("R4 ready again", rd, 16'h8000);
    wr(16'hFE06, 16'h007A);
    chk("R3 second char", {7'd0, char_valid, char_data}, 16'h017A);
    chk("R5 no overrun on legal store", {15'd0, ovr_flag}, 16'd0);
  endtask

  task automatic t_overrun();
    do_reset();
    wr(16'hFE06, 16'h0055);
    wr(16'hFE06, 16'h0066);
    chk("R5 char kept", {8'd0, char_data}, 16'h0055);
    rdw(16'hFE06, rd); chk("R5 data word kept", rd, 16'h0055);
    chk("R5 flag set", {15'd0, ovr_flag}, 16'd1);
    char_ready = 1'b1;
    @(negedge clk);
    char_ready = 1'b0;
    wr(16'hFE06, 16'h0031);
    chk("R5 flag sticky", {15'd0, ovr_flag}, 16'd1);
    do_reset();
    chk("R5 flag cleared by reset", {15'd0, ovr_flag}, 16'd0);
  endtask

  task automatic t_same_cycle();
    do_reset();
    wr(16'hFE06, 16'h0010);
    char_ready = 1'b1;
    wr(16'hFE06, 16'h0020);
    char_ready = 1'b0;
    chk("R5 accepted and dropped valid", {15'd0, char_valid}, 16'd0);
    chk("R5 collision flag", {15'd0, ovr_flag}, 16'd1);
    rdw(16'hFE06, rd); chk("R5 collision data", rd, 16'h0010);
    rdw(16'hFE04, rd); chk("R4 ready after collision", rd, 16'h8000);
  endtask

  task automatic t_ctrl();
    do_reset();
    wr(16'hFFFE, 16'h7FFF);
    chk("R7 stopped", {15'd0, run_en}, 16'd0);
    rdw(16'hFFFE, rd); chk("R7 readback", rd, 16'h7FFF);
    wr(16'hFFFE, 16'h8123);
    chk("R7 restarted", {15'd0, run_en}, 16'd1);
    rdw(16'hFFFE, rd); chk("R7 readback 2", rd, 16'h8123);
  endtask

  task automatic t_outside();
    do_reset();
    wr(16'hFE05, 16'h0000);
    wr(16'hFFFF, 16'h0000);
    wr(16'h7FFE, 16'h0000);
    wr(16'hFE07, 16'h0042);
    chk("R8 run_en untouched", {15'd0, run_en}, 16'd1);
    chk("R8 no char", {15'd0, char_valid}, 16'd0);
    rdw(16'hFE06, rd); chk("R8 data untouched", rd, 16'h0000);
    wr(16'hFE04, 16'h0000);
    rdw(16'hFE04, rd); chk("R2 status read-only", rd, 16'h8000);
    bus_addr = 16'hFE05; #1ns;
    chk("R8 outside read", bus_rdata, 16'h0000);
    chk("R8 outside sel", {15'd0, io_sel}, 16'd0);
    bus_addr = 16'hFFFE; #1ns;
    chk("R8 inside sel", {15'd0, io_sel}, 16'd1);
    bus_addr = 16'h0000;
    @(negedge clk);
  endtask

  initial begin
    t_reset();
    t_send();
    t_overrun();
    t_same_cycle();
    t_ctrl();
    t_outside();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #(20ns * 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule